// File: doc/BRIEF.md
# Glitch-Free Clock Fanout Enable Controller

This block takes two clock sources, a reference clock and a local oscillator clock. It passes the chosen one to five clock outputs, which are split into two banks. Bank A carries two outputs and bank B carries three. A select input makes the choice. An asynchronous enable request decides whether the outputs are driven.

The request is resynchronized on falling edges of the selected clock, so a gated output can only start or stop while the clock is low. No output ever shows a shortened high pulse. Each output is modelled as a tri-state pad with two signals: a clock value and a drive enable. A pad that is not driven is pulled low, so its value reads 0.

Two small state machines do the control.
- The gate machine runs on falling edges. It has the states `GATE_IDLE` and `GATE_RUN`. The transition *arm* (IDLE to RUN) fires when the synchronized request is high. The transition *stop* (RUN to IDLE) fires when it is low.
- The drive machine runs on rising edges. It has the states `DRV_OFF` and `DRV_ON`. The transition *hold* (OFF to ON) fires when the gate machine is in RUN. The transition *release* (ON to OFF) fires when it is not.

The outputs are driven while the gate is in RUN or the drive machine is in ON. With the default single synchronizer stage, the gate changes state at the second falling edge after the request changes.

Top module: `fanout_gate_ctrl`

## Requirements
- R1: While outputs are enabled, every output value equals the reference clock when `sel` is 0 and the oscillator clock when `sel` is 1.
- R2: The two bank A outputs and the three bank B outputs carry identical values and identical drive enables at all times.
- R3: While `rst_n` is low, every drive enable is 0 and every output value is 0.
- R4: After `oe_req` rises, drive enables and values stay 0 through the first falling edge of the selected clock. From the second falling edge on, drive enables are 1 and values follow the clock.
- R5: After `oe_req` falls, outputs keep following the clock through the first falling edge. From the second falling edge, values are forced to 0 with drive still 1. Drive returns to 0 at the next rising edge.
- R6: Every high pulse on an enabled output lasts exactly one full high phase of the selected clock.
- R7: If `oe_req` rises while the selected clock has no edges, outputs stay undriven at 0 and never toggle.
- R8: While disabled (after any release completes), every drive enable is 0 and every value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock source (chosen when `sel`=0) |
| osc_clk | input | 1 | Local oscillator clock source (chosen when `sel`=1) |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Source select; change only while disabled |
| oe_req | input | 1 | Asynchronous output-enable request |
| bank_a_clk | output | BANK_A_OUTS (2) | Bank A clock values |
| bank_a_drv | output | BANK_A_OUTS (2) | Bank A drive enables |
| bank_b_clk | output | BANK_B_OUTS (3) | Bank B clock values |
| bank_b_drv | output | BANK_B_OUTS (3) | Bank B drive enables |

## Verification
The bench counts falling edges of the selected clock after each request change, and it changes the request in the middle of a high phase.
- A synchronizer that is one stage too short or too long fails the drive checks at the first or second edge.
- A design that releases drive at the same falling edge that forces the value low is caught by the check that drive is still high half a cycle later.
- The width of every output high pulse is timed against the selected clock's half period. Sampling the enable on the rising edge would create runt pulses, and routing the wrong source would give a 2.5 ns pulse where 3.5 ns is expected; both fail this check.
- A stopped-clock case shows that a request alone, with no edges, must never start the outputs.

// File: rtl/fanout_pkg.sv
package fanout_pkg;

    // Gate machine, advanced on falling edges of the selected clock
    typedef enum logic {
        GATE_IDLE = 1'b0,
        GATE_RUN  = 1'b1
    } gate_state_t;

    // Drive machine, advanced on rising edges of the selected clock
    typedef enum logic {
        DRV_OFF = 1'b0,
        DRV_ON  = 1'b1
    } drive_state_t;

endpackage

// File: rtl/fo_clk_sel.sv
module fo_clk_sel (
    input  logic ref_clk,
    input  logic osc_clk,
    input  logic sel,
    output logic gclk
);
    // sel is only changed while outputs are disabled
    always_comb begin
        gclk = sel ? osc_clk : ref_clk;
    end
endmodule

// File: rtl/fo_en_sync.sv
module fo_en_sync #(
    parameter int STAGES = 1
) (
    input  logic gclk,
    input  logic rst_n,
    input  logic req,
    output logic req_s
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(negedge gclk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= req;
            end
        end else begin : g_multi
            always_ff @(negedge gclk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], req};
            end
        end
    endgenerate

    assign req_s = chain_q[STAGES-1];
endmodule

// File: rtl/fo_gate_fsm.sv
module fo_gate_fsm
    import fanout_pkg::*;
(
    input  logic gclk,
    input  logic rst_n,
    input  logic req_s,
    output logic run,
    output logic drive
);
    gate_state_t  gate_q, gate_d;
    drive_state_t drv_q,  drv_d;

    // gate state register: falling edge, so changes happen while clock is low
    always_ff @(negedge gclk or negedge rst_n) begin
        if (!rst_n) gate_q <= GATE_IDLE;
        else        gate_q <= gate_d;
    end

    // drive state register: rising edge, releases drive half a cycle late
    always_ff @(posedge gclk or negedge rst_n) begin
        if (!rst_n) drv_q <= DRV_OFF;
        else        drv_q <= drv_d;
    end

    // next-state logic
    always_comb begin
        gate_d = gate_q;
        unique case (gate_q)
            GATE_IDLE: if (req_s)  gate_d = GATE_RUN;   // arm
            GATE_RUN:  if (!req_s) gate_d = GATE_IDLE;  // stop
            default:   gate_d = GATE_IDLE;
        endcase

        drv_d = drv_q;
        unique case (drv_q)
            DRV_OFF: if (gate_q == GATE_RUN) drv_d = DRV_ON;   // hold
            DRV_ON:  if (gate_q != GATE_RUN) drv_d = DRV_OFF;  // release
            default: drv_d = DRV_OFF;
        endcase
    end

    // outputs
    always_comb begin
        run   = (gate_q == GATE_RUN);
        drive = (gate_q == GATE_RUN) || (drv_q == DRV_ON);
    end
endmodule

// File: rtl/fo_bank.sv
module fo_bank #(
    parameter int WIDTH = 2
) (
    input  logic             gclk,
    input  logic             run,
    input  logic             drive,
    output logic [WIDTH-1:0] clk_o,
    output logic [WIDTH-1:0] drv_o
);
    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_pad
            // run only changes while gclk is low: no runt pulses
            assign clk_o[g] = gclk & run;
            assign drv_o[g] = drive;
        end
    endgenerate
endmodule

// File: rtl/fanout_gate_ctrl.sv
module fanout_gate_ctrl #(
    parameter int BANK_A_OUTS = 2,
    parameter int BANK_B_OUTS = 3,
    parameter int SYNC_STAGES = 1
) (
    input  logic                   ref_clk,
    input  logic                   osc_clk,
    input  logic                   rst_n,
    input  logic                   sel,
    input  logic                   oe_req,
    output logic [BANK_A_OUTS-1:0] bank_a_clk,
    output logic [BANK_A_OUTS-1:0] bank_a_drv,
    output logic [BANK_B_OUTS-1:0] bank_b_clk,
    output logic [BANK_B_OUTS-1:0] bank_b_drv
);
    logic gclk_w;
    logic req_s_w;
    logic run_w;
    logic drive_w;

    fo_clk_sel u_sel (
        .ref_clk (ref_clk),
        .osc_clk (osc_clk),
        .sel     (sel),
        .gclk    (gclk_w)
    );

    fo_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .gclk  (gclk_w),
        .rst_n (rst_n),
        .req   (oe_req),
        .req_s (req_s_w)
    );

    fo_gate_fsm u_fsm (
        .gclk  (gclk_w),
        .rst_n (rst_n),
        .req_s (req_s_w),
        .run   (run_w),
        .drive (drive_w)
    );

    fo_bank #(.WIDTH(BANK_A_OUTS)) u_bank_a (
        .gclk  (gclk_w),
        .run   (run_w),
        .drive (drive_w),
        .clk_o (bank_a_clk),
        .drv_o (bank_a_drv)
    );

    fo_bank #(.WIDTH(BANK_B_OUTS)) u_bank_b (
        .gclk  (gclk_w),
        .run   (run_w),
        .drive (drive_w),
        .clk_o (bank_b_clk),
        .drv_o (bank_b_drv)
    );
endmodule

// File: rtl/fo_gate_checker.sv
module fo_gate_checker #(
    parameter int NA = 2,
    parameter int NB = 3
) (
    input logic          gclk,
    input logic          rst_n,
    input logic          oe_req,
    input logic          run,
    input logic          drive,
    input logic [NA-1:0] a_clk,
    input logic [NA-1:0] a_drv,
    input logic [NB-1:0] b_clk,
    input logic [NB-1:0] b_drv
);
    AST_BANKS_AGREE: assert property (@(negedge gclk) disable iff (!rst_n)
        ({a_drv, b_drv} == '0) || ({a_drv, b_drv} == '1)); // R2

    AST_UNDRIVEN_LOW: assert property (@(negedge gclk) disable iff (!rst_n)
        (a_drv[0] == 1'b0) |-> ((a_clk == '0) && (b_clk == '0))); // R8

    AST_ARM_NEEDS_REQ: assert property (@(negedge gclk) disable iff (!rst_n)
        $rose(run) |-> $past(oe_req)); // R4

    AST_RUN_HOLDS_DRIVE: assert property (@(posedge gclk) disable iff (!rst_n)
        run |-> drive); // R4

    AST_STOP_NEEDS_DROP: assert property (@(negedge gclk) disable iff (!rst_n)
        $fell(run) |-> !$past(oe_req)); // R5

    AST_RELEASE_AT_RISE: assert property (@(posedge gclk) disable iff (!rst_n)
        (!run && drive) |=> (!drive || run)); // R5
endmodule

bind fanout_gate_ctrl fo_gate_checker #(
    .NA(BANK_A_OUTS),
    .NB(BANK_B_OUTS)
) u_chk (
    .gclk   (gclk_w),
    .rst_n  (rst_n),
    .oe_req (oe_req),
    .run    (run_w),
    .drive  (drive_w),
    .a_clk  (bank_a_clk),
    .a_drv  (bank_a_drv),
    .b_clk  (bank_b_clk),
    .b_drv  (bank_b_drv)
);

// File: tb/tb_fanout_gate_ctrl.sv
`timescale 1ns/1ps
module tb_fanout_gate_ctrl;
    logic ref_clk = 1'b0;
    logic osc_clk = 1'b0;
    logic ref_on  = 1'b1;
    logic osc_on  = 1'b1;
    logic rst_n   = 1'b0;
    logic sel     = 1'b0;
    logic oe_req  = 1'b0;
    logic [1:0] a_clk, a_drv;
    logic [2:0] b_clk, b_drv;

    int  n_total = 0;
    int  n_bad   = 0;
    bit  done    = 1'b0;
    real t_up    = -1.0;

    // 200 MHz reference, slower oscillator (7 ns period)
    always begin #2.5; if (ref_on) ref_clk = ~ref_clk; end
    always begin #3.5; if (osc_on) osc_clk = ~osc_clk; end

    wire       bclk  = sel ? osc_clk : ref_clk;
    wire [4:0] o_clk = {b_clk, a_clk};
    wire [4:0] o_drv = {b_drv, a_drv};

    fanout_gate_ctrl dut (
        .ref_clk    (ref_clk),
        .osc_clk    (osc_clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .oe_req     (oe_req),
        .bank_a_clk (a_clk),
        .bank_a_drv (a_drv),
        .bank_b_clk (b_clk),
        .bank_b_drv (b_drv)
    );

    function automatic logic [4:0] rep(input logic v);
        return {5{v}};
    endfunction

    function automatic real exp_half(input logic s);
        return s ? 3.5 : 2.5;
    endfunction

    task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
        n_total++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
        end
    endtask

    // R6: every output high pulse spans one full high phase
    always @(posedge o_clk[0]) t_up = $realtime;
    always @(negedge o_clk[0]) begin
        if (t_up >= 0.0) begin
            real w;
            w = $realtime - t_up;
            n_total++;
            if (w > exp_half(sel) + 0.01 || w < exp_half(sel) - 0.01) begin
                n_bad++;
                $display("FAIL R6 pulse width actual=%0.3f expected=%0.3f", w, exp_half(sel));
            end
        end
    end

    task automatic fall_s; @(negedge bclk); #0.5; endtask
    task automatic rise_s; @(posedge bclk); #0.5; endtask

    task automatic enable_seq;
        rise_s; oe_req = 1'b1;
        fall_s; chk("R4 drv@fe1", o_drv, 5'b0); chk("R4 val@fe1", o_clk, 5'b0);
        fall_s; chk("R4 drv@fe2", o_drv, 5'h1f); chk("R4 val@fe2", o_clk, 5'b0);
        rise_s; chk("R1 val high", o_clk, 5'h1f);
    endtask

    task automatic run_cycles(input int n);
        for (int k = 0; k < n; k++) begin
            fall_s; chk("R1 low", o_clk, 5'b0);
            rise_s; chk("R1 high", o_clk, 5'h1f);
            chk("R2 banks", o_clk, rep(a_clk[0]));
            chk("R2 drives", o_drv, rep(a_drv[0]));
        end
    endtask

    task automatic disable_seq;
        rise_s; oe_req = 1'b0;
        fall_s; chk("R5 drv@fe1", o_drv, 5'h1f); chk("R5 val@fe1", o_clk, 5'b0);
        rise_s; chk("R5 still clocking", o_clk, 5'h1f);
        fall_s; chk("R5 forced low val", o_clk, 5'b0); chk("R5 drive held", o_drv, 5'h1f);
        rise_s; chk("R5 released drv", o_drv, 5'b0); chk("R5 released val", o_clk, 5'b0);
    endtask

    task automatic idle_cycles(input int n);
        for (int k = 0; k < n; k++) begin
            rise_s; chk("R8 drv", o_drv, 5'b0); chk("R8 val", o_clk, 5'b0);
        end
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary;
            $finish;
        end
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'h5EED);
        #12;
        chk("R3 drv in reset", o_drv, 5'b0);
        chk("R3 val in reset", o_clk, 5'b0);
        #1 rst_n = 1'b1;
        idle_cycles(3);

        // directed: reference source
        enable_seq; run_cycles(4); disable_seq; idle_cycles(2);

        // directed: oscillator source
        sel = 1'b1; idle_cycles(2);
        enable_seq; run_cycles(4); disable_seq; idle_cycles(2);

        // directed R7: request with the clock stopped
        sel = 1'b0; idle_cycles(1);
        fall_s; ref_on = 1'b0;
        #3 oe_req = 1'b1;
        #40 chk("R7 drv no clock", o_drv, 5'b0); chk("R7 val no clock", o_clk, 5'b0);
        #40 chk("R7 drv still", o_drv, 5'b0); chk("R7 val still", o_clk, 5'b0);
        ref_on = 1'b1;
        fall_s; chk("R4 drv after restart", o_drv, 5'b0);
        fall_s; chk("R4 drv on after restart", o_drv, 5'h1f);
        run_cycles(2); disable_seq; idle_cycles(2);

        // constrained random: source and run lengths
        for (int i = 0; i < 16; i++) begin
            sel = logic'($urandom % 2);
            idle_cycles(1 + int'($urandom % 3));
            enable_seq;
            run_cycles(1 + int'($urandom % 6));
            disable_seq;
        end

        done = 1'b1;
        summary;
        $finish;
    end
endmodule